// File: doc/BRIEF.md
# DVMA Page Table Translator

This block turns a device virtual address, carried by a DMA request, into a physical address. It takes one request at a time (address plus a write flag) and uses two configuration values from outside: a table base register and a window-start mask that marks the address bits above the translation window. From these it forms the address of a 32-bit page table entry. It fetches that entry over a single-beat memory read port, then checks the entry's permission bits.

The block answers with a one-cycle done pulse. The pulse carries either the translated physical address or a fault flag. When the answer is a fault, two registers record it: one holds an encoded fault status word and the other the page-aligned device address. Both registers can be read through a small register port. The block keeps no translation cache, and it moves no data.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_done and mem_rd_valid are 0, and both fault registers read as 0.
- R2: One cycle after a request is accepted, mem_rd_valid pulses high for exactly one cycle. mem_rd_addr equals (cfg_base << 4) + (((req_addr & ~cfg_win_start) >> 10) with its low 2 bits cleared).
- R3: For an entry that passes its checks, rsp_pa = ((entry & 0x07FFFF00) << 4) + (req_addr & 0xFFF), which places entry bits 26:8 in address bits 30:12. rsp_fault is 0.
- R4: An entry with bit 1 (valid) clear produces rsp_fault = 1, for reads and for writes alike.
- R5: A write whose entry has bit 2 (writable) clear produces a fault. A read of the same entry translates normally.
- R6: On a fault the status register loads 0xC0820000 for a write and 0xC0860000 for a read. The set bits are 31 (error), 30 (late error), 23:20 = 8, 17 (address valid) and, for reads only, 18 (read).
- R7: On a fault the address register loads req_addr with its low 12 bits cleared, and rsp_pa is 0.
- R8: rsp_done is a one-cycle pulse in the cycle after the read response arrives. Between acceptance and done, req_ready is 0 and no further request is taken, even if req_valid stays high.
- R9: A later fault overwrites both fault registers. A translation without a fault leaves them unchanged.
- R10: Entry bit 7 (cacheable) and bit 0 (write-as-zero) have no effect on rsp_pa or rsp_fault.
- R11: reg_rdata shows the status register when reg_sel is 0 and the address register when reg_sel is 1, registered one cycle after reg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Device virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| cfg_base | input | ADDR_W | Page table base register |
| cfg_win_start | input | ADDR_W | Window start mask (bits cleared from the address) |
| mem_rd_valid | output | 1 | Entry fetch request, one-cycle pulse |
| mem_rd_addr | output | ADDR_W | Byte address of the page table entry |
| mem_rd_resp_valid | input | 1 | Read response present |
| mem_rd_data | input | 32 | Page table entry returned |
| rsp_done | output | 1 | Translation finished, one-cycle pulse |
| rsp_fault | output | 1 | Translation faulted |
| rsp_pa | output | ADDR_W | Physical address, 0 on fault |
| reg_sel | input | 1 | 0 selects fault status, 1 selects fault address |
| reg_rdata | output | 32 | Registered read data of the selected fault register |

## Verification
The bench drives requests through two window masks and several base values, so a wrong shift or a wrong window clear shows up as a mismatched entry address. Entries are varied in their valid, writable, cacheable and write-as-zero bits and combined with both read and write requests. This separates the invalid fault from the permission fault and shows that the two ignored bits are ignored. Faults of the read and the write kind are interleaved with successful translations, so that the status word's read bit, the overwrite rule and the unchanged-after-success rule are each checked. Response latencies from zero to several cycles, and one request whose valid is held high through the whole transaction, test the busy behaviour and the single fetch.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int PTE_W      = 32;
  localparam int PAGE_BITS  = 12;
  localparam int BASE_SHIFT = 4;
  localparam int PPN_LO     = 8;
  localparam int PPN_HI     = 26;

  localparam int PTE_VALID_BIT = 1;
  localparam int PTE_WRITE_BIT = 2;

  localparam logic [31:0] FS_ERR    = 32'h8000_0000;
  localparam logic [31:0] FS_LATE   = 32'h4000_0000;
  localparam logic [31:0] FS_RSV8   = 32'h0080_0000;
  localparam logic [31:0] FS_RD     = 32'h0004_0000;
  localparam logic [31:0] FS_AVALID = 32'h0002_0000;

  typedef enum logic {ST_IDLE, ST_WAIT} walk_state_t;

  function automatic logic [31:0] fault_word(input logic was_read);
    fault_word = FS_ERR | FS_LATE | FS_RSV8 | FS_AVALID | (was_read ? FS_RD : 32'h0);
  endfunction
endpackage

// File: rtl/dvma_entry_addr.sv
module dvma_entry_addr
  import dvma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] win_start,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int IDX_SHIFT = PAGE_BITS - 2;

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    offs       = dev_addr & ~win_start;
    idx        = offs >> IDX_SHIFT;
    idx[1:0]   = 2'b00;
    entry_addr = (base << BASE_SHIFT) + idx;
  end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
  import dvma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [PTE_W-1:0]  pte,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              is_write,
  output logic              fault,
  output logic [ADDR_W-1:0] pa
);
  localparam int PA_BITS = PPN_HI - PPN_LO + 1 + PAGE_BITS;

  logic [PA_BITS-1:0] pa_raw;

  always_comb begin
    fault  = !pte[PTE_VALID_BIT] || (is_write && !pte[PTE_WRITE_BIT]);
    pa_raw = {pte[PPN_HI:PPN_LO], dev_addr[PAGE_BITS-1:0]};
    pa     = ADDR_W'(pa_raw);
  end
endmodule

// File: rtl/dvma_fault_log.sv
module dvma_fault_log
  import dvma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              log_en,
  input  logic              log_write,
  input  logic [ADDR_W-1:0] log_addr,
  input  logic              reg_sel,
  output logic [31:0]       stat,
  output logic [ADDR_W-1:0] far,
  output logic [31:0]       reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat      <= '0;
      far       <= '0;
      reg_rdata <= '0;
    end else begin
      if (log_en) begin
        stat <= fault_word(!log_write);
        far  <= {log_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      end
      reg_rdata <= reg_sel ? 32'(far) : stat;
    end
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_win_start,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_resp_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_pa,
  input  logic              reg_sel,
  output logic [31:0]       reg_rdata
);
  walk_state_t       state;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic [ADDR_W-1:0] ent_addr;
  logic              chk_fault;
  logic [ADDR_W-1:0] chk_pa;
  logic              resp_hit;
  logic              log_en;
  logic [31:0]       flt_stat;
  logic [ADDR_W-1:0] flt_addr;

  dvma_entry_addr #(.ADDR_W(ADDR_W)) u_ent (
    .base      (cfg_base),
    .win_start (cfg_win_start),
    .dev_addr  (req_addr),
    .entry_addr(ent_addr)
  );

  dvma_pte_check #(.ADDR_W(ADDR_W)) u_chk_pte (
    .pte     (mem_rd_data),
    .dev_addr(cur_addr),
    .is_write(cur_write),
    .fault   (chk_fault),
    .pa      (chk_pa)
  );

  assign req_ready = (state == ST_IDLE);
  assign resp_hit  = (state == ST_WAIT) && mem_rd_resp_valid;
  assign log_en    = resp_hit && chk_fault;

  dvma_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .log_en   (log_en),
    .log_write(cur_write),
    .log_addr (cur_addr),
    .reg_sel  (reg_sel),
    .stat     (flt_stat),
    .far      (flt_addr),
    .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cur_addr     <= '0;
      cur_write    <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      rsp_done     <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_pa       <= '0;
    end else begin
      mem_rd_valid <= 1'b0;
      rsp_done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr     <= req_addr;
            cur_write    <= req_write;
            mem_rd_addr  <= ent_addr;
            mem_rd_valid <= 1'b1;
            state        <= ST_WAIT;
          end
        end
        default: begin
          if (resp_hit) begin
            rsp_done  <= 1'b1;
            rsp_fault <= chk_fault;
            rsp_pa    <= chk_fault ? '0 : chk_pa;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_resp_valid,
  input logic              rsp_done,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic [31:0]       flt_stat,
  input logic [ADDR_W-1:0] flt_addr
);
  // R2: acceptance leads to one fetch pulse
  p_fetch_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_rd_valid);
  p_fetch_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid);
  // R8: busy after acceptance, done is a pulse following a response
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  p_done_after_resp_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(mem_rd_resp_valid));
  p_ready_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);
  // R7: faulting response carries no address
  p_fault_pa_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_fault) |-> (rsp_pa == '0));
  // R6: fault logs an error word with address-valid set
  p_fault_logged_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_fault) |-> (flt_stat[31] && flt_stat[30] && flt_stat[17]
                                 && flt_stat[23:20] == 4'h8));
  // R7: logged address is page aligned
  p_far_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    flt_addr[11:0] == 12'h000);
  // R9: success leaves the log untouched
  p_log_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && !rsp_fault) |-> $stable(flt_stat));
endmodule

bind dvma_xlate dvma_xlate_chk #(.ADDR_W(ADDR_W)) u_xlate_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .mem_rd_valid     (mem_rd_valid),
  .mem_rd_resp_valid(mem_rd_resp_valid),
  .rsp_done         (rsp_done),
  .rsp_fault        (rsp_fault),
  .rsp_pa           (rsp_pa),
  .flt_stat         (flt_stat),
  .flt_addr         (flt_addr)
);

// File: tb/dvma_xlate_tb.sv
`timescale 1ns/1ps
module dvma_xlate_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_win_start = '0;
  logic          mem_rd_valid;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_resp_valid = 1'b0;
  logic [31:0]   mem_rd_data = '0;
  logic          rsp_done;
  logic          rsp_fault;
  logic [AW-1:0] rsp_pa;
  logic          reg_sel = 1'b0;
  logic [31:0]   reg_rdata;

  always #5 clk = ~clk;

  dvma_xlate #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cfg_base(cfg_base),
    .cfg_win_start(cfg_win_start), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_resp_valid(mem_rd_resp_valid),
    .mem_rd_data(mem_rd_data), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
  );

  typedef struct {
    logic          fault;
    logic [AW-1:0] pa;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] ent_q[$];
  int            n_chk = 0;
  int            n_bad = 0;
  logic [31:0]   mem_pte = '0;
  int            mem_lat = 0;
  int            fetch_cnt = 0;
  logic [31:0]   exp_stat = '0;
  logic [AW-1:0] exp_far = '0;
  bit            finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: checks the entry address, answers after mem_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [AW-1:0] e;
        fetch_cnt++;
        e = (ent_q.size() != 0) ? ent_q.pop_front() : 32'hDEAD_BEEF;
        chk(mem_rd_addr == e, "R2 entry address", mem_rd_addr, e);
        for (int i = 0; i < mem_lat; i++) begin
          @(negedge clk);
          chk(!req_ready, "R8 busy while waiting", 32'(req_ready), 32'h0);
          chk(!mem_rd_valid, "R2 single fetch", 32'(mem_rd_valid), 32'h0);
        end
        mem_rd_resp_valid = 1'b1;
        mem_rd_data       = mem_pte;
        @(negedge clk);
        mem_rd_resp_valid = 1'b0;
        mem_rd_data       = '0;
      end
    end
  end

  // monitor: compares each done pulse against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_done) begin
        exp_t x;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 32'h1, 32'h0);
        end else begin
          x = exp_q.pop_front();
          chk(rsp_fault == x.fault, {x.tag, " fault flag"}, 32'(rsp_fault), 32'(x.fault));
          chk(rsp_pa == x.pa, {x.tag, " pa"}, rsp_pa, x.pa);
        end
      end
    end
  end

  task automatic xlate(input logic [AW-1:0] addr, input logic wr,
                       input logic [31:0] pte, input int lat, input bit hold,
                       input string tag);
    exp_t          x;
    logic [AW-1:0] idx;
    logic          f;
    idx      = ((addr & ~cfg_win_start) >> 10);
    idx[1:0] = 2'b00;
    ent_q.push_back((cfg_base << 4) + idx);
    f        = !pte[1] || (wr && !pte[2]);
    x.fault  = f;
    x.pa     = f ? '0 : (((pte & 32'h07FF_FF00) << 4) | (addr & 32'h0000_0FFF));
    x.tag    = tag;
    exp_q.push_back(x);
    mem_pte  = pte;
    mem_lat  = lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    req_write = wr;
    @(negedge clk);
    if (hold) begin
      while (!rsp_done) @(negedge clk);
    end
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    if (f) begin
      exp_stat = wr ? 32'hC082_0000 : 32'hC086_0000;
      exp_far  = addr & ~32'h0000_0FFF;
    end
  endtask

  task automatic rd_regs(input string tag);
    @(negedge clk);
    reg_sel = 1'b0;
    @(negedge clk);
    chk(reg_rdata == exp_stat, {tag, " status R11"}, reg_rdata, exp_stat);
    reg_sel = 1'b1;
    @(negedge clk);
    chk(reg_rdata == exp_far, {tag, " address R11"}, reg_rdata, exp_far);
    reg_sel = 1'b0;
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
    chk(rsp_done == 1'b0, "R1 done", 32'(rsp_done), 32'h0);
    chk(mem_rd_valid == 1'b0, "R1 fetch", 32'(mem_rd_valid), 32'h0);
    rd_regs("R1 reset");

    cfg_base      = 32'h0001_0000;
    cfg_win_start = 32'hFF00_0000;
    xlate(32'hFF12_3456, 1'b0, 32'h0123_4502, 0, 0, "R3 read valid");
    xlate(32'hFF00_0ABC, 1'b1, 32'h0000_1106, 2, 0, "R3 write writable");
    xlate(32'hFFFF_F001, 1'b0, 32'h07FF_FF02, 1, 0, "R5 read nonwritable");
    rd_regs("R9 still clear");
    xlate(32'hFF34_5678, 1'b1, 32'h0055_5502, 0, 0, "R5 write nonwritable");
    rd_regs("R6 write fault");
    xlate(32'hFF9A_BCDE, 1'b0, 32'h0011_1104, 3, 0, "R4 read invalid");
    rd_regs("R9 overwrite read fault");
    xlate(32'hFF00_1234, 1'b1, 32'h0033_3306, 0, 0, "R9 success after fault");
    rd_regs("R9 kept");
    xlate(32'hFF00_1234, 1'b1, 32'h0033_3387, 1, 0, "R10 cache and waz bits");
    xlate(32'hFF00_1234, 1'b0, 32'h0033_3381, 0, 0, "R10 ignored bits invalid");
    rd_regs("R4 read fault status");

    cfg_base      = 32'h0070_0400;
    cfg_win_start = 32'h8000_0000;
    xlate(32'h8765_4321, 1'b0, 32'h0246_8A02, 2, 0, "R2 wide window");
    xlate(32'h8000_0FFF, 1'b1, 32'h0000_0001, 0, 0, "R4 write invalid");
    rd_regs("R6 write invalid");

    f0 = fetch_cnt;
    xlate(32'h8ABC_D000, 1'b1, 32'h0400_0006, 4, 1, "R8 held request");
    repeat (3) @(negedge clk);
    chk(fetch_cnt == f0 + 1, "R8 one fetch for held valid", 32'(fetch_cnt - f0), 32'h1);
    chk(req_ready == 1'b1, "R8 ready again", 32'(req_ready), 32'h1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule